// File: doc/BRIEF.md
# Multi-Field Time Alarm Comparator

This block watches a running BCD time and calendar and compares it against two independent alarm register sets. Each set holds one byte for each of six fields: seconds, minutes, hours, date, month and day of week. Each byte carries its own enable bit, so a single comparator can serve a one-shot alarm, a daily alarm, a weekly alarm or any other repeating pattern. A set whose enable bits are all clear never fires.

The comparison is made once per time-update strobe, so a matching second raises the flag exactly once. A match sets that set's sticky flag, which stays set until software clears it. Each set also has an interrupt enable. An active-low interrupt line is driven low while any flag with its interrupt enable on is set. The time counter and the register access path sit outside this block.

Top module: `time_alarm_cmp`

## Requirements
- R1: Each alarm byte holds its enable in bit 7, BCD tens in bits 6:4 and BCD units in bits 3:0. Bits 6:0 are compared with the 7-bit current field. The day-of-week byte compares only bits 2:0 with the 3-bit day, and its bits 6:3 are ignored.
- R2: When the strobe `tick` is high and every enabled field of a set equals the current time, that set's flag is 1 after the next rising clock edge.
- R3: A set whose six enable bits are all 0 never sets its flag, whatever the time.
- R4: The comparison is made only on cycles where `tick` is high. A matching time with `tick` low leaves the flag unchanged.
- R5: A set flag stays 1 across later strobes with non-matching time. It returns to 0 one edge after its bit of `flag_clr` is high.
- R6: When a clear and a new match for the same set occur in the same cycle, the match wins and the flag stays 1.
- R7: The two sets are independent. A match or a clear on one set does not change the other set's flag.
- R8: `irq_n` is 0 exactly while some set has both its flag and its `irq_en` bit at 1. It follows the flags in the same cycle.
- R9: While synchronous reset `rst` is high and after it is released, both flags are 0 and `irq_n` is 1.
- R10: The hour field is compared as stored, including the PM indicator in bit 5 in 12-hour mode. An alarm of 08 AM (0x08) does not match 08 PM (0x28).
- R11: A field whose enable is 0 has no effect on the match, whatever its value and the current value. Enabling only day of week, hour and minute gives a weekly alarm, and enabling only hour and minute gives a daily alarm.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-cycle time-update strobe |
| cur_sec | input | 7 | Current seconds, BCD |
| cur_min | input | 7 | Current minutes, BCD |
| cur_hour | input | 7 | Current hour as stored, BCD with PM bit |
| cur_date | input | 7 | Current date, BCD |
| cur_month | input | 7 | Current month, BCD |
| cur_dow | input | 3 | Current day of week, 0 to 6 |
| alm_sec | input | 16 | Seconds alarm bytes, set n at bits 8n+7:8n |
| alm_min | input | 16 | Minutes alarm bytes |
| alm_hour | input | 16 | Hour alarm bytes |
| alm_date | input | 16 | Date alarm bytes |
| alm_month | input | 16 | Month alarm bytes |
| alm_dow | input | 16 | Day-of-week alarm bytes |
| flag_clr | input | 2 | Per-set flag clear |
| irq_en | input | 2 | Per-set interrupt enable |
| alm_flag | output | 2 | Sticky alarm flags |
| irq_n | output | 1 | Active-low interrupt |

## Verification
The bench first loads values that equal the current time while every enable bit is off. A design that treats an empty mask as "all fields match" would raise a flag there. It checks that the PM bit takes part in the hour comparison, that day-of-week bits 6:3 are ignored, and that disabled fields can hold any value. A design that masks the wrong bits would miss the weekly alarm or fire at the wrong half of the day. It also applies a clear in the same cycle as a new match, and holds a matching time without a strobe. A design that lets the clear win would lose an alarm, and one that compares without the strobe would fire early.

// File: rtl/talm_pkg.sv
package talm_pkg;

    localparam int BYTE_W   = 8;
    localparam int VAL_W    = 7;
    localparam int DOW_W    = 3;
    localparam int N_FIELDS = 6;

    typedef enum logic [2:0] {
        F_SEC   = 3'd0,
        F_MIN   = 3'd1,
        F_HOUR  = 3'd2,
        F_DATE  = 3'd3,
        F_MONTH = 3'd4,
        F_DOW   = 3'd5
    } field_e;

    typedef struct packed {
        logic             en;
        logic [VAL_W-1:0] val;
    } alarm_field_t;

    typedef struct packed {
        logic [VAL_W-1:0] sec;
        logic [VAL_W-1:0] min;
        logic [VAL_W-1:0] hour;
        logic [VAL_W-1:0] date;
        logic [VAL_W-1:0] month;
        logic [DOW_W-1:0] dow;
    } cal_time_t;

    function automatic logic [VAL_W-1:0] field_value(cal_time_t t, field_e f);
        case (f)
            F_SEC:   return t.sec;
            F_MIN:   return t.min;
            F_HOUR:  return t.hour;
            F_DATE:  return t.date;
            F_MONTH: return t.month;
            default: return {{(VAL_W-DOW_W){1'b0}}, t.dow};
        endcase
    endfunction

    function automatic logic [VAL_W-1:0] cmp_mask(field_e f);
        if (f == F_DOW) return {{(VAL_W-DOW_W){1'b0}}, {DOW_W{1'b1}}};
        return {VAL_W{1'b1}};
    endfunction

endpackage

// File: rtl/talm_field_cmp.sv
module talm_field_cmp
    import talm_pkg::*;
#(
    parameter field_e KIND = F_SEC
) (
    input  alarm_field_t     fld,
    input  cal_time_t        now,
    output logic             enabled,
    output logic             hit
);
    localparam logic [VAL_W-1:0] MASK = cmp_mask(KIND);

    logic [VAL_W-1:0] cur_v;

    always_comb begin
        cur_v   = field_value(now, KIND);
        enabled = fld.en;
        // A disabled field never blocks the match
        hit     = !fld.en || ((fld.val & MASK) == (cur_v & MASK));
    end
endmodule

// File: rtl/talm_set_match.sv
module talm_set_match
    import talm_pkg::*;
(
    input  alarm_field_t [N_FIELDS-1:0] flds,
    input  cal_time_t                   now,
    output logic                        match
);
    logic [N_FIELDS-1:0] en_vec;
    logic [N_FIELDS-1:0] hit_vec;

    for (genvar f = 0; f < N_FIELDS; f++) begin : g_field
        talm_field_cmp #(.KIND(field_e'(f))) i_cmp (
            .fld     (flds[f]),
            .now     (now),
            .enabled (en_vec[f]),
            .hit     (hit_vec[f])
        );
    end

    // An empty mask must never fire
    assign match = (|en_vec) && (&hit_vec);
endmodule

// File: rtl/talm_flags.sv
module talm_flags #(
    parameter int NUM_SETS = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                tick,
    input  logic [NUM_SETS-1:0] match,
    input  logic [NUM_SETS-1:0] clr,
    input  logic [NUM_SETS-1:0] irq_en,
    output logic [NUM_SETS-1:0] flag,
    output logic                irq_n
);
    logic [NUM_SETS-1:0] set_now;

    assign set_now = tick ? match : '0;

    always_ff @(posedge clk) begin
        if (rst) flag <= '0;
        else     flag <= (flag & ~clr) | set_now;  // set beats clear
    end

    assign irq_n = ~|(flag & irq_en);

    for (genvar s = 0; s < NUM_SETS; s++) begin : g_chk
        p_sticky_r5: assert property (@(posedge clk) disable iff (rst)
            (flag[s] && !clr[s]) |=> flag[s]);
        p_set_wins_r6: assert property (@(posedge clk) disable iff (rst)
            (tick && match[s]) |=> flag[s]);
        p_rise_on_tick_r4: assert property (@(posedge clk) disable iff (rst)
            (!flag[s] && !tick) |=> !flag[s]);
    end

    p_irq_quiet_r8: assert property (@(posedge clk) disable iff (rst)
        (irq_en == '0) |-> irq_n);
endmodule

// File: rtl/time_alarm_cmp.sv
module time_alarm_cmp
    import talm_pkg::*;
#(
    parameter int NUM_SETS = 2,
    localparam int AW = NUM_SETS * BYTE_W
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                tick,
    input  logic [VAL_W-1:0]    cur_sec,
    input  logic [VAL_W-1:0]    cur_min,
    input  logic [VAL_W-1:0]    cur_hour,
    input  logic [VAL_W-1:0]    cur_date,
    input  logic [VAL_W-1:0]    cur_month,
    input  logic [DOW_W-1:0]    cur_dow,
    input  logic [AW-1:0]       alm_sec,
    input  logic [AW-1:0]       alm_min,
    input  logic [AW-1:0]       alm_hour,
    input  logic [AW-1:0]       alm_date,
    input  logic [AW-1:0]       alm_month,
    input  logic [AW-1:0]       alm_dow,
    input  logic [NUM_SETS-1:0] flag_clr,
    input  logic [NUM_SETS-1:0] irq_en,
    output logic [NUM_SETS-1:0] alm_flag,
    output logic                irq_n
);
    cal_time_t           now;
    logic [NUM_SETS-1:0] set_match;

    assign now = '{sec: cur_sec, min: cur_min, hour: cur_hour,
                   date: cur_date, month: cur_month, dow: cur_dow};

    for (genvar s = 0; s < NUM_SETS; s++) begin : g_set
        alarm_field_t [N_FIELDS-1:0] flds;
        logic                        any_en;

        assign flds[F_SEC]   = alm_sec  [s*BYTE_W +: BYTE_W];
        assign flds[F_MIN]   = alm_min  [s*BYTE_W +: BYTE_W];
        assign flds[F_HOUR]  = alm_hour [s*BYTE_W +: BYTE_W];
        assign flds[F_DATE]  = alm_date [s*BYTE_W +: BYTE_W];
        assign flds[F_MONTH] = alm_month[s*BYTE_W +: BYTE_W];
        assign flds[F_DOW]   = alm_dow  [s*BYTE_W +: BYTE_W];

        talm_set_match i_match (
            .flds  (flds),
            .now   (now),
            .match (set_match[s])
        );

        assign any_en = alm_sec[s*BYTE_W+7] | alm_min[s*BYTE_W+7] |
                        alm_hour[s*BYTE_W+7] | alm_date[s*BYTE_W+7] |
                        alm_month[s*BYTE_W+7] | alm_dow[s*BYTE_W+7];

        p_no_fire_disabled_r3: assert property (@(posedge clk) disable iff (rst)
            (!alm_flag[s] && !any_en) |=> !alm_flag[s]);
        p_clear_works_r5: assert property (@(posedge clk) disable iff (rst)
            (flag_clr[s] && !(tick && set_match[s])) |=> !alm_flag[s]);
    end

    talm_flags #(.NUM_SETS(NUM_SETS)) i_flags (
        .clk    (clk),
        .rst    (rst),
        .tick   (tick),
        .match  (set_match),
        .clr    (flag_clr),
        .irq_en (irq_en),
        .flag   (alm_flag),
        .irq_n  (irq_n)
    );

    p_irq_needs_flag_r8: assert property (@(posedge clk) disable iff (rst)
        !irq_n |-> (alm_flag != '0));
endmodule

// File: tb/test_time_alarm_cmp.sv
module test_time_alarm_cmp;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic tick = 1'b0;
    logic [6:0] cur_sec = '0, cur_min = '0, cur_hour = '0, cur_date = '0, cur_month = '0;
    logic [2:0] cur_dow = '0;
    logic [7:0] a_sec [2], a_min [2], a_hour [2], a_date [2], a_month [2], a_dow [2];
    logic [1:0] flag_clr = '0, irq_en = '0;
    logic [1:0] alm_flag;
    logic       irq_n;
    int checks = 0, failures = 0;
    bit done = 0;

    always #4 clk = ~clk;

    time_alarm_cmp #(.NUM_SETS(2)) i_time_alarm_cmp (
        .clk(clk), .rst(rst), .tick(tick),
        .cur_sec(cur_sec), .cur_min(cur_min), .cur_hour(cur_hour),
        .cur_date(cur_date), .cur_month(cur_month), .cur_dow(cur_dow),
        .alm_sec({a_sec[1], a_sec[0]}), .alm_min({a_min[1], a_min[0]}),
        .alm_hour({a_hour[1], a_hour[0]}), .alm_date({a_date[1], a_date[0]}),
        .alm_month({a_month[1], a_month[0]}), .alm_dow({a_dow[1], a_dow[0]}),
        .flag_clr(flag_clr), .irq_en(irq_en), .alm_flag(alm_flag), .irq_n(irq_n)
    );

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic set_time(logic [6:0] s, logic [6:0] m, logic [6:0] h,
                            logic [6:0] d, logic [6:0] mo, logic [2:0] w);
        cur_sec = s; cur_min = m; cur_hour = h; cur_date = d; cur_month = mo; cur_dow = w;
    endtask

    task automatic set_alarm(int n, logic [7:0] s, logic [7:0] m, logic [7:0] h,
                             logic [7:0] d, logic [7:0] mo, logic [7:0] w);
        a_sec[n] = s; a_min[n] = m; a_hour[n] = h; a_date[n] = d; a_month[n] = mo; a_dow[n] = w;
    endtask

    task automatic do_tick();
        @(negedge clk) tick = 1'b1;
        @(negedge clk) tick = 1'b0;
    endtask

    task automatic do_clr(logic [1:0] m);
        @(negedge clk) flag_clr = m;
        @(negedge clk) flag_clr = '0;
    endtask

    task automatic t_reset();
        chk("R9 flags in reset", alm_flag, 2'b00);
        chk("R9 irq_n in reset", irq_n, 1'b1);
        @(negedge clk) rst = 1'b0;
        @(negedge clk);
        chk("R9 flags after reset", alm_flag, 2'b00);
    endtask

    task automatic t_all_disabled();
        // values equal the time but enables are off
        set_time(7'h15, 7'h30, 7'h08, 7'h12, 7'h06, 3'd2);
        set_alarm(0, 8'h15, 8'h30, 8'h08, 8'h12, 8'h06, 8'h02);
        set_alarm(1, 8'h15, 8'h30, 8'h08, 8'h12, 8'h06, 8'h02);
        do_tick();
        chk("R3 no enables no flag", alm_flag, 2'b00);
    endtask

    task automatic t_one_shot();
        set_alarm(0, 8'h95, 8'hB0, 8'h88, 8'h92, 8'h86, 8'h82);
        repeat (3) @(negedge clk);
        chk("R4 no tick no flag", alm_flag, 2'b00);
        do_tick();
        chk("R2 R1 full match sets flag0", alm_flag[0], 1'b1);
        chk("R7 set1 untouched", alm_flag[1], 1'b0);
    endtask

    task automatic t_sticky_clear();
        set_time(7'h16, 7'h30, 7'h08, 7'h12, 7'h06, 3'd2);
        do_tick();
        chk("R5 flag stays set", alm_flag[0], 1'b1);
        do_clr(2'b01);
        chk("R5 clear drops flag", alm_flag, 2'b00);
    endtask

    task automatic t_daily();
        // hour and minute only; other fields hold unrelated values
        set_alarm(1, 8'h59, 8'hC5, 8'h97, 8'h31, 8'h12, 8'h7E);
        set_time(7'h03, 7'h45, 7'h17, 7'h09, 7'h11, 3'd5);
        do_tick();
        chk("R11 daily alarm fires", alm_flag, 2'b10);
        do_clr(2'b10);
        set_time(7'h03, 7'h46, 7'h17, 7'h09, 7'h11, 3'd5);
        do_tick();
        chk("R11 daily minute differs", alm_flag, 2'b00);
    endtask

    task automatic t_weekly();
        // dow byte 0xFB: enable, ignored bits 6:3 set, day 3
        set_alarm(0, 8'h00, 8'h80, 8'h88, 8'h00, 8'h00, 8'hFB);
        set_time(7'h00, 7'h00, 7'h08, 7'h21, 7'h04, 3'd4);
        do_tick();
        chk("R11 weekly wrong day", alm_flag, 2'b00);
        set_time(7'h00, 7'h00, 7'h08, 7'h21, 7'h04, 3'd3);
        do_tick();
        chk("R1 R11 weekly right day", alm_flag, 2'b01);
        do_clr(2'b01);
    endtask

    task automatic t_pm_bit();
        set_time(7'h00, 7'h00, 7'h28, 7'h21, 7'h04, 3'd3);
        do_tick();
        chk("R10 PM does not match AM alarm", alm_flag, 2'b00);
    endtask

    task automatic t_set_vs_clear();
        set_time(7'h00, 7'h00, 7'h08, 7'h21, 7'h04, 3'd3);
        do_tick();
        chk("R6 pre set", alm_flag[0], 1'b1);
        @(negedge clk) begin tick = 1'b1; flag_clr = 2'b01; end
        @(negedge clk) begin tick = 1'b0; flag_clr = 2'b00; end
        chk("R6 set wins over clear", alm_flag[0], 1'b1);
    endtask

    task automatic t_irq();
        irq_en = 2'b10;
        #1 chk("R8 flag0 masked irq high", irq_n, 1'b1);
        irq_en = 2'b01;
        #1 chk("R8 flag0 enabled irq low", irq_n, 1'b0);
        do_clr(2'b01);
        chk("R8 irq high after clear", irq_n, 1'b1);
        chk("R7 clear left set1", alm_flag[1], 1'b0);
    endtask

    initial begin
        set_alarm(0, 0, 0, 0, 0, 0, 0);
        set_alarm(1, 0, 0, 0, 0, 0, 0);
        repeat (3) @(negedge clk);
        t_reset();
        t_all_disabled();
        t_one_shot();
        t_sticky_clear();
        t_daily();
        t_weekly();
        t_pm_bit();
        t_set_vs_clear();
        t_irq();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        #(8 * 100000);
        if (!done) begin
            done = 1;
            checks++;
            failures++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule